// File: doc/BRIEF.md
# Subtract-and-Branch-If-Negative Processor

A complete one-instruction computer. Its single instruction occupies three consecutive words of a unified memory and names three addresses: a destination/minuend address, a subtrahend address and a branch target. The controller reads the three address words, advancing the program counter after each, reads both operands, writes their difference back over the minuend, and keeps a copy of it in an accumulator. When that difference is negative, control transfers to the target; otherwise execution falls through to the next instruction. Clearing, copying, addition and unconditional jumps are all built from chains of this one instruction.

The memory is a single-port synchronous RAM inside the block. While the processor is idle or halted, a load port owns the RAM: it writes program and data words and reads results back. Raising the run input in the idle state starts execution at the reset program counter. A negative-result instruction whose target is its own start address is taken as a halt: the processor stops, raises its halted output, and hands the RAM back to the load port.

Top module: `subneg_cpu`

## Requirements
- R1: After reset halted_o is 0, pc_o is 0 and acc_o is 0, and the processor stays idle until run_i is 1 at a clock edge.
- R2: While idle or halted, ld_we_i=1 writes ld_wdata_i to word ld_addr_i at the clock edge, and ld_rdata_o shows the word at ld_addr_i one clock edge after the address is presented.
- R3: An instruction at address P takes its minuend address from word P, its subtrahend address from word P+1 and its target from word P+2, each the low 8 bits of the 16-bit word.
- R4: Execution stores M[minuend] - M[subtrahend], modulo 2^16, into the minuend word and shows the same value on acc_o.
- R5: The result counts as negative exactly when bit 15 is 1; a negative result loads the program counter with the target, any other result continues at P+3.
- R6: Every instruction, halting or not, takes exactly 7 clock cycles, so halted_o rises 7*N edges after the edge that samples run_i, for N executed instructions.
- R7: A negative result with target equal to P sets halted_o, freezes pc_o at P and ends execution; a zero or positive result with target P does not halt.
- R8: While executing, the load port is ignored: a write presented on it changes no memory word.
- R9: Naming the same address as minuend and subtrahend clears that word to 0 and does not branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start execution when sampled in the idle state |
| ld_we_i | input | 1 | Load port write enable (idle/halted only) |
| ld_addr_i | input | 8 | Load port word address |
| ld_wdata_i | input | 16 | Load port write data |
| ld_rdata_o | output | 16 | RAM read data, one cycle after the address |
| halted_o | output | 1 | Halt detected, sticky until reset |
| pc_o | output | 8 | Program counter |
| acc_o | output | 16 | Accumulator, copy of the last difference |

## Verification
The subtraction is tried with a three-step addition idiom, where a self-subtraction clears a scratch word and a double negation adds, so a wrong operand order or a missing write-back shows in the sum. A taken branch over a trap instruction separates a correct target load from a fall-through, and a program mixing a zero result aimed at itself, a most-negative minus one that wraps positive, and a zero minus most-negative that stays negative separates sign testing from magnitude or overflow tests and a halt rule that ignores the sign. Cycle counts to halt pin the seven-state sequence, and a load-port write issued mid-run shows whether the port is locked out.

// File: rtl/subneg_pkg.sv
package subneg_pkg;
  localparam int INSTR_WORDS = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_READ_OP1,
    ST_READ_OP2,
    ST_WRITE,
    ST_BRANCH,
    ST_HALT
  } state_e;
endpackage

// File: rtl/subneg_ram.sv
module subneg_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // read-before-write, one cycle latency
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[addr_i];
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/subneg_alu.sv
module subneg_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend_i,
  input  logic [DATA_W-1:0] subtrahend_i,
  output logic [DATA_W-1:0] diff_o
);
  assign diff_o = minuend_i - subtrahend_i;
endmodule

// File: rtl/subneg_ctrl.sv
module subneg_ctrl
  import subneg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] diff_i,
  output logic [DATA_W-1:0] op1_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam logic [ADDR_W-1:0] PC_INIT  = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] INSTR_SZ = ADDR_W'(INSTR_WORDS);

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q, start_q, a_q, b_q, c_q;
  logic [DATA_W-1:0] op1_q, acc_q;
  logic              halted_q;
  logic              neg;

  assign neg = acc_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pc_q     <= PC_INIT;
      start_q  <= PC_INIT;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      op1_q    <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (run_i) state_q <= ST_FETCH_A;
        ST_FETCH_A: begin
          start_q <= pc_q;
          pc_q    <= pc_q + PC_STEP;
          state_q <= ST_FETCH_B;
        end
        ST_FETCH_B: begin
          a_q     <= rdata_i[ADDR_W-1:0];
          pc_q    <= pc_q + PC_STEP;
          state_q <= ST_FETCH_C;
        end
        ST_FETCH_C: begin
          b_q     <= rdata_i[ADDR_W-1:0];
          pc_q    <= pc_q + PC_STEP;
          state_q <= ST_READ_OP1;
        end
        ST_READ_OP1: begin
          c_q     <= rdata_i[ADDR_W-1:0];
          state_q <= ST_READ_OP2;
        end
        ST_READ_OP2: begin
          op1_q   <= rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          acc_q   <= diff_i;
          state_q <= ST_BRANCH;
        end
        ST_BRANCH: begin
          state_q <= ST_FETCH_A;
          if (neg) begin
            pc_q <= c_q;
            if (c_q == start_q) begin
              halted_q <= 1'b1;
              state_q  <= ST_HALT;
            end
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // one RAM access per state; WRITE reuses the minuend address
  always_comb begin
    unique case (state_q)
      ST_READ_OP1: mem_addr_o = a_q;
      ST_READ_OP2: mem_addr_o = b_q;
      ST_WRITE:    mem_addr_o = a_q;
      default:     mem_addr_o = pc_q;
    endcase
  end

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = diff_i;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign op1_o       = op1_q;
  assign halted_o    = halted_q;
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;

  // R3: each fetch step advances the program counter by one
  a_r3_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH_A) |=> (pc_q == $past(pc_q) + PC_STEP));

  // R5: negative result loads the target
  a_r5_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRANCH && neg) |=> (pc_q == $past(c_q)));

  // R5: non-negative result falls through to the next instruction
  a_r5_fall_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRANCH && !neg) |=> (pc_q == $past(start_q) + INSTR_SZ));

  // R6: write is always followed by the branch step
  a_r6_write_to_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE) |=> (state_q == ST_BRANCH));

  // R7: halt is sticky and freezes the program counter
  a_r7_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(pc_q)));
endmodule

// File: rtl/subneg_cpu.sv
module subneg_cpu #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_wdata_i,
  output logic [DATA_W-1:0] ld_rdata_o,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] ram_rdata, ram_wdata, diff, op1;
  logic [DATA_W-1:0] ctrl_wdata;
  logic [ADDR_W-1:0] ram_addr, ctrl_addr;
  logic              ram_we, ctrl_we, busy;

  subneg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .rdata_i    (ram_rdata),
    .diff_i     (diff),
    .op1_o      (op1),
    .mem_addr_o (ctrl_addr),
    .mem_we_o   (ctrl_we),
    .mem_wdata_o(ctrl_wdata),
    .busy_o     (busy),
    .halted_o   (halted_o),
    .pc_o       (pc_o),
    .acc_o      (acc_o)
  );

  subneg_alu #(.DATA_W(DATA_W)) alu_i (
    .minuend_i   (op1),
    .subtrahend_i(ram_rdata),
    .diff_o      (diff)
  );

  // load port owns the RAM only while not executing
  assign ram_addr  = busy ? ctrl_addr  : ld_addr_i;
  assign ram_we    = busy ? ctrl_we    : ld_we_i;
  assign ram_wdata = busy ? ctrl_wdata : ld_wdata_i;

  subneg_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  assign ld_rdata_o = ram_rdata;

  // R4: the accumulator holds the word just written back
  a_r4_acc_matches_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ram_we) |=> (acc_o == $past(ram_wdata)));

  // R8: during execution only the controller's write step reaches the RAM
  a_r8_port_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !ctrl_we) |-> !ram_we);
endmodule

// File: tb/subneg_cpu_tb_top.sv
`timescale 1ns/1ps
module subneg_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_wdata = '0;
  logic [15:0] ld_rdata;
  logic        halted;
  logic [7:0]  pc;
  logic [15:0] acc;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  subneg_cpu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_wdata_i(ld_wdata),
    .ld_rdata_o(ld_rdata), .halted_o(halted), .pc_o(pc), .acc_o(acc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_wdata = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic instr(input logic [7:0] p, input logic [7:0] x1,
                       input logic [7:0] x2, input logic [7:0] x3);
    wr(p, {8'h00, x1});
    wr(p + 8'd1, {8'h00, x2});
    wr(p + 8'd2, {8'h00, x3});
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    ld_addr = a;
    @(posedge clk);
    #1 d = ld_rdata;
  endtask

  // returns edges counted after the run-sampling edge until halted_o
  task automatic run_prog(input bit poke, output int cycles);
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    @(negedge clk);
    run = 1'b0;
    if (poke) begin
      ld_we = 1'b1; ld_addr = 8'd18; ld_wdata = 16'd999;
    end
    cycles = 0;
    while (!halted && cycles < 1000) begin
      @(posedge clk);
      cycles++;
      #1;
      if (poke && cycles == 5) ld_we = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    check("R1 halted", {15'd0, halted}, 16'd0);
    check("R1 pc", {8'd0, pc}, 16'd0);
    check("R1 acc", acc, 16'd0);
    wr(8'd200, 16'hA5C3);
    rd(8'd200, d);
    check("R2 readback", d, 16'hA5C3);
    repeat (4) @(negedge clk);
    check("R1 stays idle", {8'd0, pc}, 16'd0);
  endtask

  // addition idiom: T=0; T=-Y; X=X-T; then halt
  task automatic t_add();
    logic [15:0] d;
    int cyc;
    do_reset();
    instr(8'd0, 8'd16, 8'd16, 8'd3);
    instr(8'd3, 8'd16, 8'd18, 8'd6);
    instr(8'd6, 8'd17, 8'd16, 8'd9);
    instr(8'd9, 8'd19, 8'd20, 8'd9);
    wr(8'd16, 16'd555);
    wr(8'd17, 16'd100);
    wr(8'd18, 16'd23);
    wr(8'd19, 16'd0);
    wr(8'd20, 16'd1);
    run_prog(1'b1, cyc);
    check("R6 add cycles", 16'(cyc), 16'd28);
    check("R7 add halted", {15'd0, halted}, 16'd1);
    check("R7 add pc", {8'd0, pc}, 16'd9);
    check("R4 add acc", acc, 16'hFFFF);
    rd(8'd17, d); check("R4 sum", d, 16'd123);
    rd(8'd16, d); check("R3 R9 scratch negated", d, 16'hFFE9);
    rd(8'd18, d); check("R8 locked port", d, 16'd23);
    rd(8'd19, d); check("R4 halt word", d, 16'hFFFF);
  endtask

  // taken branch skips a trap instruction
  task automatic t_taken();
    logic [15:0] d;
    int cyc;
    do_reset();
    instr(8'd0, 8'd16, 8'd17, 8'd6);
    instr(8'd3, 8'd18, 8'd20, 8'd3);
    instr(8'd6, 8'd19, 8'd20, 8'd6);
    wr(8'd16, 16'd5);
    wr(8'd17, 16'd9);
    wr(8'd18, 16'd7);
    wr(8'd19, 16'd0);
    wr(8'd20, 16'd1);
    run_prog(1'b0, cyc);
    check("R6 taken cycles", 16'(cyc), 16'd14);
    check("R5 taken pc", {8'd0, pc}, 16'd6);
    rd(8'd16, d); check("R4 negative diff", d, 16'hFFFC);
    rd(8'd18, d); check("R5 trap skipped", d, 16'd7);
  endtask

  // sign-only test, wrap cases, non-negative self target
  task automatic t_sign();
    logic [15:0] d;
    int cyc;
    do_reset();
    instr(8'd0, 8'd16, 8'd17, 8'd0);
    instr(8'd3, 8'd18, 8'd20, 8'd30);
    instr(8'd6, 8'd19, 8'd21, 8'd12);
    instr(8'd9, 8'd22, 8'd20, 8'd9);
    instr(8'd12, 8'd23, 8'd20, 8'd12);
    instr(8'd30, 8'd24, 8'd20, 8'd30);
    wr(8'd16, 16'd9);
    wr(8'd17, 16'd9);
    wr(8'd18, 16'h8000);
    wr(8'd19, 16'd0);
    wr(8'd20, 16'd1);
    wr(8'd21, 16'h8000);
    wr(8'd22, 16'd5);
    wr(8'd23, 16'd0);
    wr(8'd24, 16'd0);
    run_prog(1'b0, cyc);
    check("R7 no halt on zero self target", 16'(cyc), 16'd28);
    check("R5 sign pc", {8'd0, pc}, 16'd12);
    rd(8'd16, d); check("R4 zero diff", d, 16'd0);
    rd(8'd18, d); check("R5 wrap positive", d, 16'h7FFF);
    rd(8'd19, d); check("R5 wrap negative", d, 16'h8000);
    rd(8'd22, d); check("R5 skipped instr", d, 16'd5);
    rd(8'd24, d); check("R5 no wrong target", d, 16'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_taken();
    t_sign();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule